// File: doc/BRIEF.md
# Snoop Control Register Bank

This block is the software-visible register file of a multiprocessor snoop control unit that serves one to four processors. It sits on a plain 32-bit register bus with a request strobe, a write enable, a byte address, byte strobes, write data and registered read data. It holds a single enable bit and a power status word. It presents a read-only configuration word built from the processor count. Every other offset in its 256-byte window is decoded as either a quiet read-as-zero slot or an unsupported slot.

The processor count is a build-time parameter. A value outside 1 to 4 stops elaboration. Coherency, filtering, secure-state handling and access-control enforcement are not built here. Only decode, storage, reset and read-back are built.

Top module: `scu_regbank`

## Requirements
- R1: Word offset 0x00 holds the enable bit. A write with byte strobe 0 set stores write-data bit 0. A write without strobe 0 leaves the bit unchanged. A read returns the bit in bit 0 and zeros in bits 31:1.
- R2: A read of offset 0x04 returns ((2^N - 1) << 4) | (N - 1), where N is the processor count (0x72 for N = 3). Writes there change nothing.
- R3: Any write whose byte address lies in 0x08 to 0x0B targets the power status word. Each byte lane k whose strobe bit k is set takes wdata[8k+7:8k], and the other lanes keep their value. A read of 0x08 to 0x0B returns the whole word.
- R4: Offsets 0x0C, 0x40 and 0x44 read as zero and ignore writes. They never raise the unsupported flag.
- R5: Every other offset in the window, including 0x50 and 0x54, reads as zero and ignores writes. A read or write there sets `unsup_o` high for exactly the one cycle in which that access's read data would be valid.
- R6: While reset is asserted, the enable bit, the read data and the unsupported flag are cleared. The power status word keeps its value through reset.
- R7: The power status word is zero at power-on, before any write, without any reset being applied to it.
- R8: Read data appears on `rdata_o` in the cycle after the read request. It holds its value through idle cycles and write cycles until the next read.
- R9: Address bits 8 and above are ignored, so 0x108 and 0xFFFFFF08 reach the same register as 0x08.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read (valid with req_i) |
| addr_i | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| wstrb_i | input | DW/8 | Byte-lane write strobes |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| unsup_o | output | 1 | One-cycle pulse for an access to an unsupported offset |

## Verification
The enable bit is written with all-ones, all-but-bit-0 and a strobe that misses lane 0. These patterns separate a correct bit-0 store from a full-word store and from a write that ignores strobes. The power word takes a full-lane write and then a single-lane write at a misaligned byte address. This shows whether lanes are merged and whether the low address bits are dropped. Accesses to quiet slots, unsupported slots and high-aliased addresses, and a reset in the middle of the sequence, separate the read-as-zero cases from each other by the flag. They also show which state survives reset. A behavioural model runs beside the design and compares both outputs on every cycle.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;

    localparam int DW = 32;

    // word offsets (byte address bits 7:2)
    localparam logic [5:0] W_CTRL   = 6'h00;
    localparam logic [5:0] W_CFG    = 6'h01;
    localparam logic [5:0] W_PWR    = 6'h02;
    localparam logic [5:0] W_INV    = 6'h03;
    localparam logic [5:0] W_FILT_S = 6'h10;
    localparam logic [5:0] W_FILT_E = 6'h11;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_CFG,
        SEL_PWR,
        SEL_QUIET,
        SEL_UNSUP
    } sel_e;

    typedef struct packed {
        logic          ctrl;
        logic [DW-1:0] pwr;
        logic [DW-1:0] rdata;
        logic          unsup;
    } regs_t;

endpackage

// File: rtl/scu_addr_decode.sv
module scu_addr_decode
    import scu_regs_pkg::*;
#(
    parameter int WIN_AW = 8
) (
    input  logic [WIN_AW-1:0] off_i,
    output sel_e              sel_o
);
    localparam int WORD_AW = WIN_AW - 2;

    logic [WORD_AW-1:0] word;
    logic [1:0]         unused_lane;

    assign word        = off_i[WIN_AW-1:2];
    assign unused_lane = off_i[1:0];

    always_comb begin
        unique case (word)
            WORD_AW'(W_CTRL):   sel_o = SEL_CTRL;
            WORD_AW'(W_CFG):    sel_o = SEL_CFG;
            WORD_AW'(W_PWR):    sel_o = SEL_PWR;
            WORD_AW'(W_INV),
            WORD_AW'(W_FILT_S),
            WORD_AW'(W_FILT_E): sel_o = SEL_QUIET;
            default:            sel_o = SEL_UNSUP;
        endcase
    end
endmodule

// File: rtl/scu_cfg_word.sv
module scu_cfg_word #(
    parameter int NUM_CPU = 4,
    parameter int DW      = 32
) (
    output logic [DW-1:0] cfg_o
);
    localparam int unsigned PRESENT = (1 << NUM_CPU) - 1;
    localparam int unsigned CNT_M1  = NUM_CPU - 1;

    assign cfg_o = DW'((PRESENT << 4) | CNT_M1);
endmodule

// File: rtl/scu_byte_merge.sv
module scu_byte_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   old_i,
    input  logic [DW-1:0]   new_i,
    input  logic [DW/8-1:0] strb_i,
    output logic [DW-1:0]   merged_o
);
    localparam int LANES = DW / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged_o[8*k +: 8] = strb_i[k] ? new_i[8*k +: 8] : old_i[8*k +: 8];
    end
endmodule

// File: rtl/scu_regbank.sv
module scu_regbank
    import scu_regs_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 32,
    parameter int WIN_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW/8-1:0]   wstrb_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              unsup_o
);
    if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
        $fatal(1, "scu_regbank: NUM_CPU must be 1..4");
    end
    if (ADDR_W <= WIN_AW) begin : g_bad_aw
        $fatal(1, "scu_regbank: ADDR_W must exceed WIN_AW");
    end

    sel_e          sel;
    logic [DW-1:0] cfg_word;
    logic [DW-1:0] pwr_merged;
    logic          unused_addr_hi;

    // power-on load doubles as the defined initial value of the power word
    regs_t regs_q = '0;
    regs_t regs_d;

    assign unused_addr_hi = ^addr_i[ADDR_W-1:WIN_AW];

    scu_addr_decode #(.WIN_AW(WIN_AW)) dec_i (
        .off_i (addr_i[WIN_AW-1:0]),
        .sel_o (sel)
    );

    scu_cfg_word #(.NUM_CPU(NUM_CPU), .DW(DW)) cfg_i (
        .cfg_o (cfg_word)
    );

    scu_byte_merge #(.DW(DW)) merge_i (
        .old_i    (regs_q.pwr),
        .new_i    (wdata_i),
        .strb_i   (wstrb_i),
        .merged_o (pwr_merged)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.unsup = req_i && (sel == SEL_UNSUP);

        if (req_i && we_i) begin
            unique case (sel)
                SEL_CTRL: if (wstrb_i[0]) regs_d.ctrl = wdata_i[0];
                SEL_PWR:  regs_d.pwr = pwr_merged;
                default:  ;
            endcase
        end

        if (req_i && !we_i) begin
            unique case (sel)
                SEL_CTRL: regs_d.rdata = {{(DW-1){1'b0}}, regs_q.ctrl};
                SEL_CFG:  regs_d.rdata = cfg_word;
                SEL_PWR:  regs_d.rdata = regs_q.pwr;
                default:  regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl  <= 1'b0;
            regs_q.rdata <= '0;
            regs_q.unsup <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = regs_q.rdata;
    assign unsup_o = regs_q.unsup;
endmodule

// File: rtl/scu_regbank_chk.sv
module scu_regbank_chk
    import scu_regs_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 32,
    parameter int WIN_AW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DW/8-1:0]   wstrb_i,
    input logic [DW-1:0]     wdata_i,
    input logic [DW-1:0]     rdata_o,
    input logic              unsup_o
);
    localparam logic [DW-1:0] CFG_EXP =
        DW'((((1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1));

    logic [5:0] w;
    logic       rd;
    logic       wr;
    assign w  = addr_i[7:2];
    assign rd = req_i && !we_i;
    assign wr = req_i && we_i;

    // R1
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && w == W_CTRL |=> rdata_o[DW-1:1] == '0);

    // R2
    cfg_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && w == W_CFG |=> rdata_o == CFG_EXP);

    // R3
    pwr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && w == W_PWR && wstrb_i == '1 ##1 rd && w == W_PWR
        |=> rdata_o == $past(wdata_i, 2));

    // R4
    quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (w == W_INV || w == W_FILT_S || w == W_FILT_E)
        |=> rdata_o == '0 && !unsup_o);

    // R5
    unsup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> $past(req_i));

    // R5
    unsup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o && $past(!we_i) |-> rdata_o == '0);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata_o));
endmodule

bind scu_regbank scu_regbank_chk #(
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W),
    .WIN_AW  (WIN_AW)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wstrb_i (wstrb_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .unsup_o (unsup_o)
);

// File: tb/scu_regbank_tb_top.sv
module scu_regbank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 3;
    localparam logic [31:0] CFG_REF = 32'h72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  wstrb = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        unsup;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state
    logic        m_ctrl = 1'b0;
    logic [31:0] m_pwr  = '0;
    logic [31:0] m_rd   = '0;
    logic        m_uns  = 1'b0;
    int          m_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    scu_regbank #(.NUM_CPU(NCPU)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .we_i    (we),
        .addr_i  (addr),
        .wstrb_i (wstrb),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .unsup_o (unsup)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 1'b0;
            m_rd   = '0;
            m_uns  = 1'b0;
        end else begin
            m_word = int'(addr[7:0]) / 4;
            m_uns  = req && !(m_word inside {0, 1, 2, 3, 16, 17});
            if (req && !we) begin
                case (m_word)
                    0:       m_rd = {31'd0, m_ctrl};
                    1:       m_rd = CFG_REF;
                    2:       m_rd = m_pwr;
                    default: m_rd = '0;
                endcase
            end
            if (req && we) begin
                if (m_word == 0 && wstrb[0]) m_ctrl = wdata[0];
                if (m_word == 2)
                    for (int b = 0; b < 4; b++)
                        if (wstrb[b]) m_pwr[8*b +: 8] = wdata[8*b +: 8];
            end
        end
    end

    // per-cycle comparison against the reference model (R8, R5)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rdata !== m_rd || unsup !== m_uns) begin
                errors++;
                $display("FAIL R8 model: rdata=%h unsup=%b expected rdata=%h unsup=%b",
                         rdata, unsup, m_rd, m_uns);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        req = 1'b1; we = 1'b0; addr = a; wstrb = '0;
        @(negedge clk);
        req = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R6 reset state
        chk("R6 rdata in reset", rdata, 32'h0);
        chk("R6 unsup in reset", {31'd0, unsup}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 power-on value
        rd(32'h08, 32'h0, "R7 power-on status");

        // R2 configuration word, writes ignored
        rd(32'h04, CFG_REF, "R2 cfg read");
        wr(32'h04, 32'hFFFF_FFFF, 4'hF);
        rd(32'h04, CFG_REF, "R2 cfg after write");

        // R1 enable bit
        wr(32'h00, 32'hFFFF_FFFF, 4'hF);
        rd(32'h00, 32'h1, "R1 ctrl all ones");
        wr(32'h00, 32'hFFFF_FFFE, 4'hF);
        rd(32'h00, 32'h0, "R1 ctrl bit0 clear");
        wr(32'h00, 32'h0000_0001, 4'h2);
        rd(32'h00, 32'h0, "R1 ctrl lane0 not strobed");

        // R3 power status byte lanes and byte range
        wr(32'h08, 32'h1122_3344, 4'hF);
        rd(32'h08, 32'h1122_3344, "R3 full write");
        wr(32'h0B, 32'hAABB_CCDD, 4'h4);
        rd(32'h09, 32'h11BB_3344, "R3 lane 2 via 0x0B, read via 0x09");

        // R4 quiet slots
        wr(32'h40, 32'hFFFF_FFFF, 4'hF);
        wr(32'h0C, 32'hFFFF_FFFF, 4'hF);
        chk("R4 no flag on quiet write", {31'd0, unsup}, 32'h0);
        rd(32'h40, 32'h0, "R4 filter start");
        rd(32'h44, 32'h0, "R4 filter end");
        rd(32'h0C, 32'h0, "R4 invalidate slot");
        chk("R4 no flag on quiet read", {31'd0, unsup}, 32'h0);
        rd(32'h08, 32'h11BB_3344, "R4 power word untouched");

        // R5 unsupported slots
        rd(32'h50, 32'h0, "R5 read 0x50");
        chk("R5 flag on read", {31'd0, unsup}, 32'h1);
        idle(1);
        chk("R5 flag single cycle", {31'd0, unsup}, 32'h0);
        wr(32'h54, 32'hFFFF_FFFF, 4'hF);
        chk("R5 flag on write", {31'd0, unsup}, 32'h1);
        wr(32'h80, 32'hFFFF_FFFF, 4'hF);
        wr(32'hFC, 32'hFFFF_FFFF, 4'hF);
        rd(32'h00, 32'h0, "R5 ctrl untouched");
        rd(32'h08, 32'h11BB_3344, "R5 power untouched");

        // R8 hold across idle and writes
        rd(32'h04, CFG_REF, "R8 read");
        idle(3);
        chk("R8 hold over idle", rdata, CFG_REF);
        wr(32'h00, 32'h1, 4'h1);
        chk("R8 hold over write", rdata, CFG_REF);

        // R9 high address bits ignored
        wr(32'hFFFF_FF08, 32'h0000_0055, 4'h1);
        rd(32'h0000_0108, 32'h11BB_3355, "R9 aliased power word");
        rd(32'h8000_0000, 32'h1, "R9 aliased ctrl");

        // R6 reset clears ctrl, keeps power word
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 rdata cleared", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(32'h00, 32'h0, "R6 ctrl cleared");
        rd(32'h08, 32'h11BB_3355, "R6 power kept");

        idle(2);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule